// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the 16-bit control port of a video display processor. Each word written to the port is either a register write or one half of a two-word access command. Register writes go into a small register file holding the transfer setup (source address, length, auto-increment step) and the base addresses of the display tables. Command words are paired by a half-command latch. The pair is then split into a 6-bit access code and a 16-bit destination address.

The access code selects which on-chip memory a following data-port access reaches: video RAM, colour RAM or vertical-scroll RAM. When the code asks for a transfer, the block also raises a one-cycle start request naming the transfer kind. A transfer engine consumes the source address, length and step values. It reports each finished unit on `remainDec`, so the remaining count runs down. A 32-bit host write is presented as two word writes on consecutive cycles.

Top module: `vcp_cmd_port`

## Requirements
- R1: A word written with bits 15:14 equal to binary 10 is a register write: bits 12:8 give the index and bits 7:0 the value. Such a word leaves the half-command latch (`halfPending`) unchanged, even when a first half is already held.
- R2: Any other word is a command half. With `halfPending` low it is stored and `halfPending` goes high. With `halfPending` high it completes the command and `halfPending` goes low.
- R3: On completion, `accessCode` bits 1:0 become bits 15:14 of the first word and bits 5:2 become bits 7:4 of the second word. `destAddr` bits 13:0 become bits 13:0 of the first word and bits 15:14 become bits 1:0 of the second word.
- R4: `targetSel` is found from `accessCode` AND 0x0E: a result of 0 gives 0 (video RAM), 4 gives 2 (vertical-scroll RAM), and any other result gives 1 (colour RAM).
- R5: In the cycle after a completing word, `startReq` is high for exactly one cycle when code bit 5 is set. `startMode` is then 2 (copy within video RAM) if code bit 4 is set. It is 1 (bus-to-memory) if code bit 4 is clear and bit 7 of register 23 is clear. If code bit 4 is clear and that bit is set, there is no request. `startMode` is 0 whenever `startReq` is low.
- R6: Register 19 is the low byte and register 20 the high byte of `xferLen`. A write to either one also loads `remainCount` with the new length. Otherwise `remainDec` lowers `remainCount` by one per cycle, stopping at zero.
- R7: Registers 21, 22 and 23 place their values into `srcAddr` shifted left by 1, 9 and 17, and `srcAddr` bit 0 is always 0. Register 23 contributes its bits 6:0 when its bit 7 is clear, and only its bits 5:0 when bit 7 is set.
- R8: Register 16 holds the plane size. Bits 1:0 give `scrollW` and bits 5:4 give `scrollH`, each decoded as 00 to 32, 01 to 64 and 11 to 128 cells. The code 10 in either field gives 0 cells and raises `scrollSizeBad`.
- R9: Table bases are the register value shifted left and truncated to 16 bits: register 2 by 10 (`planeABase`), register 4 by 13 (`planeBBase`), register 5 by 9 (`spriteBase`) and register 13 by 10 (`hscrollBase`). Register 15 drives `autoInc`.
- R10: Register writes to any index not named in R6 to R9 change no output.
- R11: A synchronous reset clears the half-command latch, the command outputs, the start request and every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Control-port write strobe |
| wrData | input | 16 | Control-port word |
| remainDec | input | 1 | Transfer engine finished one unit |
| halfPending | output | 1 | First command half is held |
| accessCode | output | 6 | Assembled access code |
| destAddr | output | 16 | Assembled destination address |
| targetSel | output | 2 | 0 video RAM, 1 colour RAM, 2 vertical-scroll RAM |
| startReq | output | 1 | One-cycle transfer start request |
| startMode | output | 2 | 0 none, 1 bus-to-memory, 2 video RAM copy |
| srcAddr | output | 24 | Transfer source address |
| xferLen | output | 16 | Programmed transfer length |
| remainCount | output | 16 | Units still to move |
| autoInc | output | 8 | Destination step per access |
| planeABase | output | 16 | Plane A table base |
| planeBBase | output | 16 | Plane B table base |
| spriteBase | output | 16 | Sprite table base |
| hscrollBase | output | 16 | Horizontal-scroll table base |
| scrollW | output | 8 | Plane width in cells |
| scrollH | output | 8 | Plane height in cells |
| scrollSizeBad | output | 1 | A plane size field holds the invalid code |

## Verification
The hardest case to reach is a register write that arrives between the two halves of a command. The latch must survive it, and the later second word must still pair with the first word that was stored before the register write. The stimulus sends a first half and then a register write. It checks that `halfPending` is still high, then sends the second half and checks the assembled code and address. A second hard case is the start decision that depends on the source-high mode bit. The bench programs register 23 both ways before sending the same transfer command, and expects a request in one case and silence in the other.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 5;
  localparam int VAL_W  = 8;
  localparam int CODE_W = 6;
  localparam int SRC_W  = 24;
  localparam int LEN_W  = 16;
  localparam int BASE_W = 16;
  localparam int NUM_BASES = 4;

  localparam logic [IDX_W-1:0] IDX_PLANE_A  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_PLANE_B  = 5'd4;
  localparam logic [IDX_W-1:0] IDX_SPRITE   = 5'd5;
  localparam logic [IDX_W-1:0] IDX_HSCROLL  = 5'd13;
  localparam logic [IDX_W-1:0] IDX_AUTOINC  = 5'd15;
  localparam logic [IDX_W-1:0] IDX_PLANESZ  = 5'd16;
  localparam logic [IDX_W-1:0] IDX_LEN_LO   = 5'd19;
  localparam logic [IDX_W-1:0] IDX_LEN_HI   = 5'd20;
  localparam logic [IDX_W-1:0] IDX_SRC_LO   = 5'd21;
  localparam logic [IDX_W-1:0] IDX_SRC_MID  = 5'd22;
  localparam logic [IDX_W-1:0] IDX_SRC_HI   = 5'd23;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_BUS  = 2'd1,
    XFER_COPY = 2'd2
  } xfer_e;

  typedef struct packed {
    logic regWr;
    logic firstHalf;
    logic secondHalf;
  } strobe_t;

  function automatic logic [7:0] decodeCells(input logic [1:0] field);
    case (field)
      2'b00:   decodeCells = 8'd32;
      2'b01:   decodeCells = 8'd64;
      2'b11:   decodeCells = 8'd128;
      default: decodeCells = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/vcp_ctrl.sv
module vcp_ctrl
  import vcp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [1:0]  topBits,
  input  logic [1:0]  codeHi,
  input  logic        srcHiFlag,
  output strobe_t     strobe,
  output logic        halfPending,
  output logic        startReq,
  output logic [1:0]  startMode
);
  logic isReg;
  logic pendingQ;

  always_comb begin
    isReg             = (topBits == 2'b10);
    strobe.regWr      = wrEn && isReg;
    strobe.firstHalf  = wrEn && !isReg && !pendingQ;
    strobe.secondHalf = wrEn && !isReg && pendingQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ  <= 1'b0;
      startReq  <= 1'b0;
      startMode <= XFER_NONE;
    end else begin
      if (strobe.firstHalf)       pendingQ <= 1'b1;
      else if (strobe.secondHalf) pendingQ <= 1'b0;

      startReq  <= 1'b0;
      startMode <= XFER_NONE;
      if (strobe.secondHalf && codeHi[1]) begin
        if (codeHi[0]) begin
          startReq  <= 1'b1;
          startMode <= XFER_COPY;
        end else if (!srcHiFlag) begin
          startReq  <= 1'b1;
          startMode <= XFER_BUS;
        end
      end
    end
  end

  assign halfPending = pendingQ;
endmodule

// File: rtl/vcp_regs.sv
module vcp_regs
  import vcp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobe,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                remainDec,
  output logic                srcHiFlag,
  output logic [CODE_W-1:0]   accessCode,
  output logic [WORD_W-1:0]   destAddr,
  output logic [1:0]          targetSel,
  output logic [SRC_W-1:0]    srcAddr,
  output logic [LEN_W-1:0]    xferLen,
  output logic [LEN_W-1:0]    remainCount,
  output logic [VAL_W-1:0]    autoInc,
  output logic [BASE_W-1:0]   planeABase,
  output logic [BASE_W-1:0]   planeBBase,
  output logic [BASE_W-1:0]   spriteBase,
  output logic [BASE_W-1:0]   hscrollBase,
  output logic [7:0]          scrollW,
  output logic [7:0]          scrollH,
  output logic                scrollSizeBad
);
  localparam int HI_KEEP = SRC_W - 17;

  logic [IDX_W-1:0]  regIdx;
  logic [VAL_W-1:0]  regVal;
  logic [WORD_W-1:0] firstWord;
  logic [VAL_W-1:0]  srcLo, srcMid, srcHi;
  logic [VAL_W-1:0]  lenLo, lenHi;
  logic [VAL_W-1:0]  sizeReg;
  logic [VAL_W-1:0]  incReg;
  logic [VAL_W-1:0]  baseReg [NUM_BASES];
  logic [BASE_W-1:0] baseOut [NUM_BASES];
  logic [HI_KEEP-1:0] srcHiMasked;
  logic              lenWrite;

  assign regIdx   = wrData[12:8];
  assign regVal   = wrData[VAL_W-1:0];
  assign lenWrite = strobe.regWr && (regIdx == IDX_LEN_LO || regIdx == IDX_LEN_HI);

  // command assembly
  always_ff @(posedge clk) begin
    if (rst) begin
      firstWord  <= '0;
      accessCode <= '0;
      destAddr   <= '0;
    end else begin
      if (strobe.firstHalf) firstWord <= wrData;
      if (strobe.secondHalf) begin
        accessCode <= {wrData[7:4], firstWord[15:14]};
        destAddr   <= {wrData[1:0], firstWord[13:0]};
      end
    end
  end

  always_comb begin
    case (accessCode & 6'h0E)
      6'h00:   targetSel = TGT_VRAM;
      6'h04:   targetSel = TGT_VSRAM;
      default: targetSel = TGT_CRAM;
    endcase
  end

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      srcLo   <= '0;
      srcMid  <= '0;
      srcHi   <= '0;
      lenLo   <= '0;
      lenHi   <= '0;
      sizeReg <= '0;
      incReg  <= '0;
      for (int i = 0; i < NUM_BASES; i++) baseReg[i] <= '0;
    end else if (strobe.regWr) begin
      case (regIdx)
        IDX_PLANE_A: baseReg[0] <= regVal;
        IDX_PLANE_B: baseReg[1] <= regVal;
        IDX_SPRITE:  baseReg[2] <= regVal;
        IDX_HSCROLL: baseReg[3] <= regVal;
        IDX_AUTOINC: incReg     <= regVal;
        IDX_PLANESZ: sizeReg    <= regVal;
        IDX_LEN_LO:  lenLo      <= regVal;
        IDX_LEN_HI:  lenHi      <= regVal;
        IDX_SRC_LO:  srcLo      <= regVal;
        IDX_SRC_MID: srcMid     <= regVal;
        IDX_SRC_HI:  srcHi      <= regVal;
        default: ;
      endcase
    end
  end

  // remaining count, reloaded by either length half
  always_ff @(posedge clk) begin
    if (rst) begin
      remainCount <= '0;
    end else if (lenWrite) begin
      remainCount <= (regIdx == IDX_LEN_LO) ? {lenHi, regVal} : {regVal, lenLo};
    end else if (remainDec && remainCount != '0) begin
      remainCount <= remainCount - 1'b1;
    end
  end

  // table bases: shift amounts per slot
  generate
    for (genvar g = 0; g < NUM_BASES; g++) begin : gBase
      localparam int SHIFT = (g == 0) ? 10 : (g == 1) ? 13 : (g == 2) ? 9 : 10;
      logic [BASE_W+VAL_W-1:0] wide;
      assign wide       = {{BASE_W{1'b0}}, baseReg[g]} << SHIFT;
      assign baseOut[g] = wide[BASE_W-1:0];
    end
  endgenerate

  assign planeABase  = baseOut[0];
  assign planeBBase  = baseOut[1];
  assign spriteBase  = baseOut[2];
  assign hscrollBase = baseOut[3];

  assign srcHiMasked = srcHi[7] ? {1'b0, srcHi[5:0]} : srcHi[6:0];
  assign srcAddr     = {srcHiMasked, srcMid, srcLo, 1'b0};
  assign srcHiFlag   = srcHi[7];
  assign xferLen     = {lenHi, lenLo};
  assign autoInc     = incReg;

  assign scrollW       = decodeCells(sizeReg[1:0]);
  assign scrollH       = decodeCells(sizeReg[5:4]);
  assign scrollSizeBad = (sizeReg[1:0] == 2'b10) || (sizeReg[5:4] == 2'b10);
endmodule

// File: rtl/vcp_cmd_port.sv
module vcp_cmd_port
  import vcp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        remainDec,
  output logic        halfPending,
  output logic [5:0]  accessCode,
  output logic [15:0] destAddr,
  output logic [1:0]  targetSel,
  output logic        startReq,
  output logic [1:0]  startMode,
  output logic [23:0] srcAddr,
  output logic [15:0] xferLen,
  output logic [15:0] remainCount,
  output logic [7:0]  autoInc,
  output logic [15:0] planeABase,
  output logic [15:0] planeBBase,
  output logic [15:0] spriteBase,
  output logic [15:0] hscrollBase,
  output logic [7:0]  scrollW,
  output logic [7:0]  scrollH,
  output logic        scrollSizeBad
);
  strobe_t strobe;
  logic    srcHiFlag;

  vcp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .topBits    (wrData[15:14]),
    .codeHi     (wrData[7:6]),
    .srcHiFlag  (srcHiFlag),
    .strobe     (strobe),
    .halfPending(halfPending),
    .startReq   (startReq),
    .startMode  (startMode)
  );

  vcp_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .wrData       (wrData),
    .remainDec    (remainDec),
    .srcHiFlag    (srcHiFlag),
    .accessCode   (accessCode),
    .destAddr     (destAddr),
    .targetSel    (targetSel),
    .srcAddr      (srcAddr),
    .xferLen      (xferLen),
    .remainCount  (remainCount),
    .autoInc      (autoInc),
    .planeABase   (planeABase),
    .planeBBase   (planeBBase),
    .spriteBase   (spriteBase),
    .hscrollBase  (hscrollBase),
    .scrollW      (scrollW),
    .scrollH      (scrollH),
    .scrollSizeBad(scrollSizeBad)
  );
endmodule

// File: rtl/vcp_cmd_port_chk.sv
module vcp_cmd_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        halfPending,
  input logic [1:0]  targetSel,
  input logic        startReq,
  input logic [1:0]  startMode,
  input logic [23:0] srcAddr,
  input logic [15:0] xferLen,
  input logic [15:0] remainCount
);
  logic isRegWord;
  assign isRegWord = wrEn && (wrData[15:14] == 2'b10);

  assert_reg_keeps_latch_R1: assert property (@(posedge clk) disable iff (rst)
    isRegWord |=> halfPending == $past(halfPending));

  assert_cmd_flips_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !isRegWord) |=> halfPending != $past(halfPending));

  assert_target_legal_R4: assert property (@(posedge clk) disable iff (rst)
    targetSel != 2'b11);

  assert_start_after_pair_R5: assert property (@(posedge clk) disable iff (rst)
    startReq |-> ($past(wrEn) && $past(halfPending)));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    startReq |=> !startReq);

  assert_start_mode_R5: assert property (@(posedge clk) disable iff (rst)
    startReq ? (startMode != 2'd0) : (startMode == 2'd0));

  assert_len_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (isRegWord && (wrData[12:8] == 5'd19 || wrData[12:8] == 5'd20)) |=> remainCount == xferLen);

  assert_src_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (isRegWord && wrData[12:8] == 5'd23 && wrData[7]) |=> !srcAddr[23]);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!halfPending && !startReq && srcAddr == 24'd0));
endmodule

bind vcp_cmd_port vcp_cmd_port_chk u_chk (.*);

// File: tb/vcp_cmd_port_tb.sv
module vcp_cmd_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic        remainDec = 1'b0;
  logic        halfPending;
  logic [5:0]  accessCode;
  logic [15:0] destAddr;
  logic [1:0]  targetSel;
  logic        startReq;
  logic [1:0]  startMode;
  logic [23:0] srcAddr;
  logic [15:0] xferLen, remainCount;
  logic [7:0]  autoInc;
  logic [15:0] planeABase, planeBBase, spriteBase, hscrollBase;
  logic [7:0]  scrollW, scrollH;
  logic        scrollSizeBad;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vcp_cmd_port u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'h0;
  endtask

  task automatic regWr(input int idx, input logic [7:0] v);
    wr(16'h8000 | 16'(idx << 8) | {8'h0, v});
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  function automatic logic [15:0] base(input logic [7:0] v, input int sh);
    logic [31:0] t;
    t = {24'h0, v} << sh;
    return t[15:0];
  endfunction

  function automatic logic [1:0] tgtOf(input logic [5:0] c);
    logic [5:0] m;
    m = c & 6'h0E;
    if (m == 6'h00) return 2'd0;
    if (m == 6'h04) return 2'd2;
    return 2'd1;
  endfunction

  task automatic t_reset();
    chk("R11 pending", halfPending, 0);
    chk("R11 code", accessCode, 0);
    chk("R11 src", srcAddr, 0);
    chk("R11 start", startReq, 0);
    chk("R11 len", xferLen, 0);
    chk("R8 default width", scrollW, 32);
  endtask

  task automatic t_bases();
    regWr(2, 8'h3F);  chk("R9 planeA", planeABase, base(8'h3F, 10));
    regWr(4, 8'h07);  chk("R9 planeB", planeBBase, base(8'h07, 13));
    regWr(5, 8'h7F);  chk("R9 sprite", spriteBase, base(8'h7F, 9));
    regWr(13, 8'h2A); chk("R9 hscroll", hscrollBase, base(8'h2A, 10));
    regWr(15, 8'h02); chk("R9 autoInc", autoInc, 8'h02);
    chk("R1 latch idle after regs", halfPending, 0);
  endtask

  task automatic t_reserved();
    regWr(6, 8'hFF);
    regWr(31, 8'hFF);
    regWr(0, 8'hFF);
    chk("R10 planeA", planeABase, base(8'h3F, 10));
    chk("R10 planeB", planeBBase, base(8'h07, 13));
    chk("R10 sprite", spriteBase, base(8'h7F, 9));
    chk("R10 hscroll", hscrollBase, base(8'h2A, 10));
    chk("R10 autoInc", autoInc, 8'h02);
    chk("R10 src", srcAddr, 0);
    chk("R10 len", xferLen, 0);
    chk("R10 width", scrollW, 32);
    chk("R10 pending", halfPending, 0);
  endtask

  task automatic cmd(input string tag, input logic [15:0] a, input logic [15:0] b);
    logic [5:0] ec;
    ec = {b[7:4], a[15:14]};
    wr(a);
    chk({tag, " R2 pending set"}, halfPending, 1);
    wr(b);
    chk({tag, " R2 pending clear"}, halfPending, 0);
    chk({tag, " R3 code"}, accessCode, ec);
    chk({tag, " R3 addr"}, destAddr, {b[1:0], a[13:0]});
    chk({tag, " R4 target"}, targetSel, tgtOf(ec));
  endtask

  task automatic t_commands();
    cmd("vram", 16'h4123, 16'h0002);
    cmd("cram", 16'hC3FF, 16'h0001);
    cmd("vsram", 16'h4010, 16'h0013);
    cmd("cram2", 16'h0000, 16'h0030);
  endtask

  task automatic t_reg_between();
    wr(16'h4ABC);
    regWr(15, 8'h04);
    chk("R1 latch held across reg", halfPending, 1);
    chk("R1 reg applied", autoInc, 8'h04);
    wr(16'h0003);
    chk("R1 pair code", accessCode, 6'h01);
    chk("R1 pair addr", destAddr, 16'hCABC);
    chk("R1 pending clear", halfPending, 0);
  endtask

  task automatic t_starts();
    regWr(23, 8'h01);
    wr(16'h0000); wr(16'h00C0);
    chk("R5 copy req", startReq, 1);
    chk("R5 copy mode", startMode, 2);
    @(negedge clk);
    chk("R5 copy one cycle", startReq, 0);
    chk("R5 mode idle", startMode, 0);
    wr(16'h0000); wr(16'h0080);
    chk("R5 bus req", startReq, 1);
    chk("R5 bus mode", startMode, 1);
    regWr(23, 8'h80);
    wr(16'h0000); wr(16'h0080);
    chk("R5 fill no req", startReq, 0);
    chk("R5 fill no mode", startMode, 0);
    wr(16'h0000); wr(16'h0040);
    chk("R5 no bit5 no req", startReq, 0);
  endtask

  task automatic t_source();
    logic [23:0] e;
    regWr(21, 8'hAB); regWr(22, 8'hCD); regWr(23, 8'h7F);
    e = (24'h7F << 17) | (24'hCD << 9) | (24'hAB << 1);
    chk("R7 src 7bit", srcAddr, e);
    regWr(23, 8'hFF);
    e = (24'h3F << 17) | (24'hCD << 9) | (24'hAB << 1);
    chk("R7 src 6bit", srcAddr, e);
  endtask

  task automatic t_length();
    regWr(19, 8'h10); regWr(20, 8'h02);
    chk("R6 len", xferLen, 16'h0210);
    chk("R6 remain", remainCount, 16'h0210);
    @(negedge clk); remainDec = 1'b1;
    repeat (3) @(negedge clk);
    remainDec = 1'b0;
    chk("R6 dec", remainCount, 16'h020D);
    regWr(19, 8'h05);
    chk("R6 reload low", remainCount, 16'h0205);
    regWr(20, 8'h00);
    chk("R6 reload high", remainCount, 16'h0005);
    regWr(19, 8'h02);
    @(negedge clk); remainDec = 1'b1;
    repeat (4) @(negedge clk);
    remainDec = 1'b0;
    chk("R6 floor zero", remainCount, 16'h0000);
  endtask

  task automatic t_scroll();
    regWr(16, 8'h31);
    chk("R8 w64", scrollW, 64); chk("R8 h128", scrollH, 128); chk("R8 ok", scrollSizeBad, 0);
    regWr(16, 8'h02);
    chk("R8 w bad", scrollW, 0); chk("R8 bad flag w", scrollSizeBad, 1);
    regWr(16, 8'h23);
    chk("R8 h bad", scrollH, 0); chk("R8 bad flag h", scrollSizeBad, 1);
  endtask

  task automatic t_reset_mid();
    wr(16'h4001);
    doReset();
    chk("R11 latch cleared", halfPending, 0);
    chk("R11 src cleared", srcAddr, 0);
    chk("R11 base cleared", planeABase, 0);
    chk("R11 remain cleared", remainCount, 0);
    wr(16'h4002);
    chk("R11 fresh first half", halfPending, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bases();
    t_reserved();
    t_commands();
    t_reg_between();
    t_starts();
    t_source();
    t_length();
    t_scroll();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule